// File: doc/BRIEF.md
# Microprogrammed memory cycle sequencer

This block generates the control waveforms of an external memory access by stepping through a small pattern RAM, one word per clock. Each 32-bit word carries 24 control bits, which go straight to the memory pins, and a set of flow flags. The flags can mark a hardware loop, allow a branch to an exception pattern when the bus times out, request an address increment, raise transfer acknowledge, start a per-bank hold-off timer and end the pattern. A host loads the RAM through a write port. A requester asks for an access by giving a start address, a bank number and a port width. A mode input supplies the loop count, the exception pattern address and the hold-off period.

The controller `memseq_engine` has three states. In IDLE it drives zero controls and waits. When a request arrives for a bank that is not blocked, the accept transition moves it to RUN. In RUN it executes one word per cycle. From RUN there are four transitions: the exception branch (RUN to RUN at the exception address), the loop-back (RUN to RUN at the loop start word), finish to IDLE, and finish to HOLD. The finish to HOLD transition is taken when the final word started the bank timer and a request for the same bank is already waiting. HOLD keeps the final word's control bits on the pins until the timer of that bank runs out. HOLD then leaves by accept (to RUN) or by release (to IDLE). `memseq_hold_timers` keeps one down-counter per bank, and `memseq_ram` holds the pattern words.

Top module: `memseq_top`

## Requirements
- R1: While a pattern runs, `ctrl_out` equals bits 23..0 of the current word. Words are taken one per clock, starting at the accepted `req_addr`. In IDLE, `ctrl_out` is zero. Bits 26 and 27 of a word have no effect.
- R2: `xfer_ack` is high in exactly the cycles whose word has bit 29 set.
- R3: A word with bit 28 set makes `addr_inc` high in the following cycle. In that cycle `addr_step` is 1 when the access was requested with `req_port16`=0 and 2 when it was requested with `req_port16`=1. Otherwise `addr_inc` is low and `addr_step` is zero.
- R4: A word with bit 31 set is the final cycle of the pattern. `done` is high for exactly the one cycle that follows it and is low while words execute.
- R5: Bit 24 marks loop words. The first marked word executed in a pattern is the loop start, and the next different marked word is the loop end. The words from start to end run `mode_loop_count` times in total, with 0 acting as 1. Marked words met after the loop has completed are ignored.
- R6: If `bus_timeout` is high in the cycle of a word with bit 25 set, the next word is read from `mode_exc_addr`. This branch takes precedence over bit 31 and over the loop. Inside the exception pattern, timeouts and loop marks are ignored, and execution continues until a word with bit 31 set.
- R7: A `bus_timeout` during a word whose bit 25 is clear has no effect on the sequence.
- R8: A word with bits 30 and 31 both set blocks its bank for `mode_hold_period` cycles. Bit 30 without bit 31 has no effect: a request for the same bank is taken in the cycle after the final word.
- R9: When the timer was started and a request for the same bank is pending at the final word, `ctrl_out` keeps the final word's bits and `req_taken` stays low for the following P cycles (P = `mode_hold_period`). The request is taken in cycle P+1. A request for another bank is taken in cycle 1.
- R10: After reset, `ctrl_out`, `xfer_ack`, `addr_inc`, `addr_step`, `done` and `req_taken` are all zero while `req` is low.
- R11: `req_taken` is high in the cycle in which a request is accepted. It is high only when the sequencer is not running and the bank of the request is not blocked. The first word appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ram_we | input | 1 | Pattern RAM write strobe |
| ram_waddr | input | ADDR_W | Pattern RAM write address |
| ram_wdata | input | 32 | Pattern word to store |
| req | input | 1 | Access request, held until taken |
| req_addr | input | ADDR_W | First word of the requested pattern |
| req_bank | input | BANK_W | Bank of the request |
| req_port16 | input | 1 | 1 for a 16-bit port, 0 for an 8-bit port |
| mode_loop_count | input | LOOP_W | Total loop body executions |
| mode_exc_addr | input | ADDR_W | Exception pattern address |
| mode_hold_period | input | HOLD_W | Bank hold-off period in cycles |
| bus_timeout | input | 1 | Bus monitor timeout |
| req_taken | output | 1 | Request accepted this cycle |
| ctrl_out | output | 24 | Memory control signals |
| xfer_ack | output | 1 | Transfer acknowledge |
| addr_inc | output | 1 | Address increment strobe |
| addr_step | output | 2 | Increment amount (1 or 2) |
| done | output | 1 | Pattern completed pulse |

## Verification
The assertions check several properties on every cycle. They confirm that `done` never lasts two cycles and that the pins stay stable across HOLD. They also check that `addr_step` is 1 or 2 exactly when `addr_inc` is high, that a bank timer is never restarted while it still runs, and that no request is taken for a blocked bank. Other properties can only be shown by the bench scenarios: the loop iteration count, the exception branch and its precedence over the final word, timeouts being ignored when bit 25 is clear, the exact hold-off length, and other banks not being delayed. The bench checks these against a cycle model of the word flow, under directed patterns and randomly generated ones.

// File: rtl/memseq_pkg.sv
package memseq_pkg;
    localparam int WORD_W   = 32;
    localparam int CTRL_W   = 24;
    localparam int B_LOOP   = 24;
    localparam int B_EXCEN  = 25;
    localparam int B_INC    = 28;
    localparam int B_ACK    = 29;
    localparam int B_TIMER  = 30;
    localparam int B_LAST   = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;
endpackage

// File: rtl/memseq_ram.sv
module memseq_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/memseq_hold_timers.sv
module memseq_hold_timers #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int HOLD_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [BANK_W-1:0]    start_bank,
    input  logic [HOLD_W-1:0]    period,
    output logic [NUM_BANKS-1:0] blocked
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [HOLD_W-1:0] cnt_q;
        logic              hit;

        assign hit = start && (start_bank == BANK_W'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (hit) begin
                cnt_q <= period;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - HOLD_W'(1);
            end
        end

        assign blocked[b] = (cnt_q != '0);

        // R8: a bank timer is only started once it has run out
        assert_no_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> (cnt_q == '0));
    end
endmodule

// File: rtl/memseq_engine.sv
module memseq_engine
    import memseq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BANK_W = 2,
    parameter int LOOP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    output logic [ADDR_W-1:0] pc,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_port16,
    input  logic              blk_req,
    input  logic              blk_own,
    input  logic [LOOP_W-1:0] mode_loop_count,
    input  logic [ADDR_W-1:0] mode_exc_addr,
    input  logic              hold_nonzero,
    input  logic              bus_timeout,
    output logic [BANK_W-1:0] bank,
    output logic              timer_start,
    output logic              req_taken,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic              xfer_ack,
    output logic              addr_inc,
    output logic [1:0]        addr_step,
    output logic              done
);
    seq_state_t state_q, state_d;

    logic [ADDR_W-1:0] pc_q, loop_start_q;
    logic [BANK_W-1:0] bank_q;
    logic              port16_q;
    logic [LOOP_W-1:0] rem_q;
    logic              loop_seen_q, loop_done_q, in_exc_q;
    logic [CTRL_W-1:0] hold_ctrl_q;
    logic              done_q, inc_q;
    logic [1:0]        step_q;

    logic running, take, exc_hit, loop_flag, loop_end, loop_back, finish;

    always_comb begin
        running   = (state_q == ST_RUN);
        take      = !running && req && !blk_req;
        exc_hit   = running && word[B_EXCEN] && bus_timeout && !in_exc_q;
        loop_flag = word[B_LOOP] && !loop_done_q;
        loop_end  = loop_flag && loop_seen_q && (pc_q != loop_start_q);
        loop_back = loop_end && (rem_q > LOOP_W'(1));
        finish    = running && word[B_LAST] && !exc_hit;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take) state_d = ST_RUN;
            ST_RUN: begin
                if (finish) begin
                    if (word[B_TIMER] && req && (req_bank == bank_q) && hold_nonzero)
                        state_d = ST_HOLD;
                    else
                        state_d = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (take)          state_d = ST_RUN;
                else if (!blk_own) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q         <= '0;
            loop_start_q <= '0;
            bank_q       <= '0;
            port16_q     <= 1'b0;
            rem_q        <= '0;
            loop_seen_q  <= 1'b0;
            loop_done_q  <= 1'b0;
            in_exc_q     <= 1'b0;
            hold_ctrl_q  <= '0;
            done_q       <= 1'b0;
            inc_q        <= 1'b0;
            step_q       <= 2'd0;
        end else begin
            done_q <= finish;
            inc_q  <= running && word[B_INC];
            step_q <= (running && word[B_INC]) ? (port16_q ? 2'd2 : 2'd1) : 2'd0;
            if (finish) begin
                hold_ctrl_q <= word[CTRL_W-1:0];
            end
            if (take) begin
                pc_q        <= req_addr;
                bank_q      <= req_bank;
                port16_q    <= req_port16;
                rem_q       <= mode_loop_count;
                loop_seen_q <= 1'b0;
                loop_done_q <= 1'b0;
                in_exc_q    <= 1'b0;
            end else if (exc_hit) begin
                pc_q        <= mode_exc_addr;
                in_exc_q    <= 1'b1;
                loop_done_q <= 1'b1;
            end else if (running && !word[B_LAST]) begin
                if (loop_flag && !loop_seen_q) begin
                    loop_seen_q  <= 1'b1;
                    loop_start_q <= pc_q;
                end
                if (loop_back) begin
                    rem_q <= rem_q - LOOP_W'(1);
                    pc_q  <= loop_start_q;
                end else begin
                    if (loop_end) loop_done_q <= 1'b1;
                    pc_q <= pc_q + ADDR_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        ctrl_out = '0;
        xfer_ack = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                ctrl_out = word[CTRL_W-1:0];
                xfer_ack = word[B_ACK];
            end
            ST_HOLD: ctrl_out = hold_ctrl_q;
            default: ctrl_out = '0;
        endcase
        pc          = pc_q;
        bank        = bank_q;
        timer_start = finish && word[B_TIMER];
        req_taken   = take;
        addr_inc    = inc_q;
        addr_step   = step_q;
        done        = done_q;
    end

    // R4: completion pulse lasts one cycle
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: pins stay frozen across the hold-off wait
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> $stable(ctrl_out));
    // R3: step amount present exactly with the strobe
    assert_step_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_inc |-> (addr_step == 2'd1 || addr_step == 2'd2));
    assert_step_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_inc |-> (addr_step == 2'd0));
    // R4: completion only follows an executing cycle
    assert_done_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state_q) == ST_RUN));
endmodule

// File: rtl/memseq_top.sv
module memseq_top
    import memseq_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int LOOP_W    = 4,
    parameter int HOLD_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_we,
    input  logic [ADDR_W-1:0] ram_waddr,
    input  logic [31:0]       ram_wdata,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_port16,
    input  logic [LOOP_W-1:0] mode_loop_count,
    input  logic [ADDR_W-1:0] mode_exc_addr,
    input  logic [HOLD_W-1:0] mode_hold_period,
    input  logic              bus_timeout,
    output logic              req_taken,
    output logic [23:0]       ctrl_out,
    output logic              xfer_ack,
    output logic              addr_inc,
    output logic [1:0]        addr_step,
    output logic              done
);
    logic [WORD_W-1:0]    word;
    logic [ADDR_W-1:0]    pc;
    logic [BANK_W-1:0]    bank;
    logic                 timer_start;
    logic [NUM_BANKS-1:0] blocked;

    memseq_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) ram_i (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(pc), .rdata(word)
    );

    memseq_hold_timers #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .HOLD_W(HOLD_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .start(timer_start), .start_bank(bank),
        .period(mode_hold_period), .blocked(blocked)
    );

    memseq_engine #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .LOOP_W(LOOP_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .word(word), .pc(pc),
        .req(req), .req_addr(req_addr), .req_bank(req_bank), .req_port16(req_port16),
        .blk_req(blocked[req_bank]), .blk_own(blocked[bank]),
        .mode_loop_count(mode_loop_count), .mode_exc_addr(mode_exc_addr),
        .hold_nonzero(mode_hold_period != '0), .bus_timeout(bus_timeout),
        .bank(bank), .timer_start(timer_start), .req_taken(req_taken),
        .ctrl_out(ctrl_out), .xfer_ack(xfer_ack), .addr_inc(addr_inc),
        .addr_step(addr_step), .done(done)
    );

    // R11: never accept a request for a bank still held off
    assert_no_blocked_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_taken |-> !blocked[req_bank]);
endmodule

// File: tb/memseq_top_tb_top.sv
module memseq_top_tb_top;
    localparam int ADDR_W = 6;
    localparam int BANK_W = 2;
    localparam int LOOP_W = 4;
    localparam int HOLD_W = 5;
    localparam int HOLD_P = 6;
    localparam int EXC_A  = 48;

    logic clk = 1'b0;
    logic rst_n, ram_we, req, req_port16, bus_timeout;
    logic [ADDR_W-1:0] ram_waddr, req_addr, mode_exc_addr;
    logic [31:0] ram_wdata;
    logic [BANK_W-1:0] req_bank;
    logic [LOOP_W-1:0] mode_loop_count;
    logic [HOLD_W-1:0] mode_hold_period;
    logic req_taken, xfer_ack, addr_inc, done;
    logic [23:0] ctrl_out;
    logic [1:0] addr_step;

    logic [31:0] img [64];
    int n_run = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    memseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .ram_wdata(ram_wdata), .req(req), .req_addr(req_addr), .req_bank(req_bank),
        .req_port16(req_port16), .mode_loop_count(mode_loop_count),
        .mode_exc_addr(mode_exc_addr), .mode_hold_period(mode_hold_period),
        .bus_timeout(bus_timeout), .req_taken(req_taken), .ctrl_out(ctrl_out),
        .xfer_ack(xfer_ack), .addr_inc(addr_inc), .addr_step(addr_step), .done(done)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [31:0] d);
        img[a] = d;
        ram_we = 1'b1; ram_waddr = ADDR_W'(a); ram_wdata = d;
        @(negedge clk);
        ram_we = 1'b0;
    endtask

    function automatic logic [31:0] mk(input logic [23:0] c, input bit lp, input bit ex,
                                       input bit inc, input bit ack, input bit tm, input bit last);
        return {last, tm, ack, inc, 2'b00, ex, lp, c};
    endfunction

    // Executes one pattern against the cycle model; returns cycles used and final ctrl.
    task automatic run_pat(input int sa, input int bk, input bit p16, input int tmo_k,
                           input bit chain, input int c_bank, input int c_addr,
                           output int cycles, output logic [23:0] last_c);
        int pc, ls, rem, k, wd;
        bit seen, ldone, inexc, fin, exc, lflag, lend;
        bit pinc;
        logic [1:0] pstep;
        logic [31:0] w;
        req = 1'b1; req_addr = ADDR_W'(sa); req_bank = BANK_W'(bk); req_port16 = p16;
        #1;
        wd = 0;
        while (!req_taken && wd < 300) begin @(negedge clk); #1; wd++; end
        chk(req_taken == 1'b1, "R11", "req_taken before start", req_taken, 1);
        @(negedge clk);
        req = 1'b0;
        pc = sa; ls = 0; rem = (mode_loop_count == 0) ? 1 : int'(mode_loop_count);
        seen = 0; ldone = 0; inexc = 0; pinc = 0; pstep = 2'd0; fin = 0;
        k = 0;
        while (!fin && k < 200) begin
            bus_timeout = (k == tmo_k);
            w = img[pc];
            chk(ctrl_out == w[23:0], "R1", "ctrl_out", ctrl_out, w[23:0]);
            chk(xfer_ack == w[29], "R2", "xfer_ack", xfer_ack, w[29]);
            chk(addr_inc == pinc && addr_step == pstep, "R3", "addr_inc/step",
                {addr_inc, addr_step}, {pinc, pstep});
            chk(done == 1'b0, "R4", "done during run", done, 0);
            pinc = w[28];
            pstep = w[28] ? (p16 ? 2'd2 : 2'd1) : 2'd0;
            exc = w[25] && bus_timeout && !inexc;
            lflag = w[24] && !ldone;
            lend = lflag && seen && (pc != ls);
            if (exc) begin
                pc = EXC_A; inexc = 1; ldone = 1;
            end else if (w[31]) begin
                fin = 1;
                last_c = w[23:0];
                if (chain) begin
                    req = 1'b1; req_bank = BANK_W'(c_bank); req_addr = ADDR_W'(c_addr);
                end
            end else if (lflag && !seen) begin
                seen = 1; ls = pc; pc++;
            end else if (lend && rem > 1) begin
                rem--; pc = ls;
            end else begin
                if (lend) ldone = 1;
                pc++;
            end
            @(negedge clk);
            bus_timeout = 1'b0;
            k++;
        end
        cycles = k;
        chk(done == 1'b1, "R4", "done after final word", done, 1);
        chk(addr_inc == pinc && addr_step == pstep, "R3", "addr_inc after final",
            {addr_inc, addr_step}, {pinc, pstep});
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        int cyc, c;
        logic [23:0] lc;
        void'($urandom(32'd4242));
        rst_n = 1'b0; ram_we = 1'b0; ram_waddr = '0; ram_wdata = '0;
        req = 1'b0; req_addr = '0; req_bank = '0; req_port16 = 1'b0; bus_timeout = 1'b0;
        mode_loop_count = 4'd1; mode_exc_addr = ADDR_W'(EXC_A);
        mode_hold_period = HOLD_W'(HOLD_P);
        repeat (3) @(negedge clk);
        chk(ctrl_out == 0 && xfer_ack == 0 && addr_inc == 0 && addr_step == 0
            && done == 0 && req_taken == 0, "R10", "reset outputs",
            {ctrl_out, xfer_ack, addr_inc, addr_step, done, req_taken}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // exception pattern: loop marks and exception flag inside must be ignored (R6)
        put(48, mk(24'hE00001, 1, 0, 0, 0, 0, 0));
        put(49, mk(24'hE00002, 0, 1, 0, 1, 0, 0));
        put(50, mk(24'hE00003, 1, 0, 0, 0, 0, 0));
        put(51, mk(24'hE00004, 0, 0, 0, 0, 0, 1));

        // R1 R2 R3: straight pattern, reserved bits set in word 1
        put(0, mk(24'h000A11, 0, 0, 1, 0, 0, 0));
        put(1, mk(24'h000A22, 0, 0, 0, 1, 0, 0) | 32'h0C00_0000);
        put(2, mk(24'h000A33, 0, 0, 1, 1, 0, 1));
        run_pat(0, 0, 1'b1, -1, 0, 0, 0, cyc, lc);
        chk(cyc == 3, "R1", "straight length", cyc, 3);
        @(negedge clk);
        chk(ctrl_out == 0, "R1", "idle ctrl", ctrl_out, 0);

        // R5: loop body words 9..11, count 3 then 0
        put(8,  mk(24'h000B01, 0, 0, 0, 0, 0, 0));
        put(9,  mk(24'h000B02, 1, 0, 1, 0, 0, 0));
        put(10, mk(24'h000B03, 0, 0, 0, 1, 0, 0));
        put(11, mk(24'h000B04, 1, 0, 0, 0, 0, 0));
        put(12, mk(24'h000B05, 1, 0, 0, 0, 0, 0));
        put(13, mk(24'h000B06, 0, 0, 0, 1, 0, 1));
        mode_loop_count = 4'd3;
        run_pat(8, 0, 1'b0, -1, 0, 0, 0, cyc, lc);
        chk(cyc == 12, "R5", "loop count 3 length", cyc, 12);
        mode_loop_count = 4'd0;
        run_pat(8, 0, 1'b0, -1, 0, 0, 0, cyc, lc);
        chk(cyc == 6, "R5", "loop count 0 length", cyc, 6);
        mode_loop_count = 4'd2;

        // R6: branch taken on a final word with exception enable
        put(16, mk(24'h000C01, 0, 0, 0, 0, 0, 0));
        put(17, mk(24'h000C02, 0, 1, 0, 0, 0, 1));
        run_pat(16, 0, 1'b0, 1, 0, 0, 0, cyc, lc);
        chk(cyc == 6, "R6", "exception path length", cyc, 6);
        // R7: timeout on word without exception enable is ignored
        run_pat(16, 0, 1'b0, 0, 0, 0, 0, cyc, lc);
        chk(cyc == 2, "R7", "ignored timeout length", cyc, 2);

        // R8 R9: timer start with same-bank request pending
        put(20, mk(24'h000D01, 0, 0, 0, 0, 1, 0));
        put(21, mk(24'h000D02, 0, 0, 0, 1, 1, 1));
        run_pat(20, 1, 1'b0, -1, 1, 1, 0, cyc, lc);
        c = 1;
        while (!req_taken && c < 100) begin
            chk(ctrl_out == lc, "R9", "held ctrl", ctrl_out, lc);
            @(negedge clk); c++;
        end
        chk(c == HOLD_P + 1, "R9", "same-bank take cycle", c, HOLD_P + 1);
        run_pat(0, 1, 1'b0, -1, 0, 0, 0, cyc, lc);

        // R9: other bank not delayed, idle pins meanwhile
        run_pat(20, 3, 1'b0, -1, 1, 0, 0, cyc, lc);
        chk(req_taken == 1'b1, "R9", "other bank taken at cycle 1", req_taken, 1);
        chk(ctrl_out == 0, "R9", "other bank idle ctrl", ctrl_out, 0);
        run_pat(0, 0, 1'b0, -1, 0, 0, 0, cyc, lc);

        // R8: timer flag without final flag has no effect
        put(24, mk(24'h000E01, 0, 0, 0, 0, 1, 0));
        put(25, mk(24'h000E02, 0, 0, 0, 0, 0, 1));
        run_pat(24, 2, 1'b0, -1, 1, 2, 0, cyc, lc);
        chk(req_taken == 1'b1, "R8", "no hold without final flag", req_taken, 1);
        run_pat(0, 2, 1'b0, -1, 0, 0, 0, cyc, lc);

        // random patterns at 32..39
        for (int it = 0; it < 60; it++) begin
            int n, a, b, tk;
            bit lp;
            n = 2 + int'($urandom_range(6));
            lp = (n >= 4) && ($urandom_range(1) == 1);
            a = lp ? int'($urandom_range(n - 3)) : -1;
            b = lp ? a + 1 + int'($urandom_range(n - 3 - a)) : -1;
            for (int i = 0; i < n; i++) begin
                logic [31:0] wv;
                wv = mk(24'($urandom), (i == a) || (i == b), $urandom_range(3) == 0,
                        $urandom_range(1) == 1, $urandom_range(1) == 1, 0, i == n - 1);
                wv[27:26] = 2'($urandom);
                put(32 + i, wv);
            end
            mode_loop_count = LOOP_W'($urandom_range(3));
            tk = ($urandom_range(2) == 0) ? -1 : int'($urandom_range(n * 3));
            run_pat(32, int'($urandom_range(3)), 1'($urandom), tk, 0, 0, 0, cyc, lc);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule